// File: doc/BRIEF.md
# Channel-Counted Mailbox Queue Unit

This unit sits between a compute core and a host that reaches it over a small register bus. It holds three queues of 32-bit words. Two carry words from the core out to the host: a plain one, and one that holds an interrupt line high while it has data. The third carries words from the host in to the core. The core reaches the queues through a channel port that offers read, write and read-count operations.

Each core-side channel keeps a count. For an outgoing channel the count is the number of free slots. For the incoming channel it is the number of words waiting. When the count is zero, a read or write is not dropped. The core is held with a stall output until the host frees a slot or supplies a word. The access then completes in that same cycle. The count can always be read without blocking, so software can poll instead of stalling. An access in the wrong direction, or to the unused channel number, completes at once with a one-cycle error pulse and changes nothing.

On the host side, reading an outgoing queue pops its head. Writing the incoming data address pushes a word. A status word reports the queue fill and a sticky overflow flag.

Top module: `mbox_chan_unit`

## Requirements
- R1: After reset, the read-count operation returns 1 for channel 0 (outgoing) and for channel 1 (outgoing with interrupt), and 0 for channel 2 (incoming). `hs_irq`, `ch_stall`, `ch_err` and the overflow flag are 0.
- R2: A write (`ch_op`=2'b10) to channel 0 or 1 whose count is non-zero asserts `ch_done` in the same cycle and decrements the count. The host then reads the word at address 0 (channel 0) or address 1 (channel 1). The read pops the word and restores the count.
- R3: A write to an outgoing channel whose count is zero holds `ch_stall` high and `ch_done` low for as long as the queue stays full. In the cycle the host reads that queue, the write completes and the new word replaces the popped one, so the count stays 0.
- R4: A read (`ch_op`=2'b01) of channel 2 with count zero stalls. In the cycle the host writes address 2, the read completes and `ch_rdata` carries the host's word directly, leaving the count at 0.
- R5: The incoming queue holds up to 4 words. The core reads them back in the order the host wrote them, and the channel 2 count equals the number of words held.
- R6: The read-count operation (`ch_op`=2'b11) never stalls. It asserts `ch_done`, returns the count zero-extended on `ch_rdata`, and changes no state.
- R7: Each of the following asserts `ch_err` for that cycle, with `ch_done` and `ch_stall` low and no count or queue change:
  - a read of channel 0 or 1;
  - a write of channel 2;
  - any read or write of channel 3.
- R8: `hs_irq` is high exactly while the channel 1 queue holds a word. Words in channel 0 do not raise it.
- R9: A host read of an empty outgoing queue returns zero and changes no count.
- R10: A host write to address 2 while the incoming queue is full, with no core read in that cycle, is dropped. It sets an overflow flag that stays set until reset.
- R11: A host read of address 3 returns a status word:
  - bit 0: channel 0 queue non-empty;
  - bit 1: channel 1 queue non-empty;
  - bit 2: overflow flag;
  - bits 15:8: incoming fill level.

  A host read of address 2 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_op | input | 2 | Core operation: 00 idle, 01 read, 10 write, 11 read-count |
| ch_sel | input | 2 | Channel: 0 outgoing, 1 outgoing with interrupt, 2 incoming, 3 unused |
| ch_wdata | input | 32 | Core write data |
| ch_rdata | output | 32 | Core read data or count |
| ch_done | output | 1 | Core access completes this cycle |
| ch_stall | output | 1 | Core access held this cycle |
| ch_err | output | 1 | Wrong-direction or unused-channel access |
| hs_wr | input | 1 | Host write strobe |
| hs_rd | input | 1 | Host read strobe |
| hs_addr | input | 2 | Host word address: 0, 1 outgoing data, 2 incoming data, 3 status |
| hs_wdata | input | 32 | Host write data |
| hs_rdata | output | 32 | Host read data, valid in the strobe cycle |
| hs_irq | output | 1 | Interrupt: channel 1 queue not empty |

## Verification
The assertions take for granted that a stalled core holds `ch_op`, `ch_sel` and `ch_wdata` steady until `ch_done`. They also assume the host never raises `hs_rd` and `hs_wr` in the same cycle. The directed tasks drive each request once after a falling edge and keep it until the cycle in which they expect completion. They issue host strobes one at a time. Neither input is changed between falling edges.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DW = 32;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_RCNT  = 2'b11
  } ch_op_e;

  typedef enum logic [1:0] {
    CH_OUT  = 2'd0,
    CH_OUTI = 2'd1,
    CH_IN   = 2'd2,
    CH_NONE = 2'd3
  } ch_sel_e;

  localparam logic [1:0] HA_OUT  = 2'd0;
  localparam logic [1:0] HA_OUTI = 2'd1;
  localparam logic [1:0] HA_IN   = 2'd2;
  localparam logic [1:0] HA_STAT = 2'd3;

  // next value of a channel count given one increment and one decrement
  function automatic int step_count(int cur, logic up, logic dn);
    return cur + (up ? 1 : 0) - (dn ? 1 : 0);
  endfunction

  // an access is legal when its direction matches the channel
  function automatic logic dir_legal(ch_op_e op, ch_sel_e sel);
    case (op)
      OP_READ:  return sel == CH_IN;
      OP_WRITE: return (sel == CH_OUT) || (sel == CH_OUTI);
      OP_RCNT:  return sel != CH_NONE;
      default:  return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 32,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  generate
    if (DEPTH == 1) begin : g_single
      logic          vld_q;
      logic [DW-1:0] dat_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          dat_q <= '0;
        end else begin
          if (push) begin
            vld_q <= 1'b1;
            dat_q <= wdata;
          end else if (pop) begin
            vld_q <= 1'b0;
          end
        end
      end
      assign head  = dat_q;
      assign level = LW'(vld_q);
    end else begin : g_ring
      localparam int AW = $clog2(DEPTH);
      logic [DW-1:0] mem_q [DEPTH];
      logic [AW-1:0] wp_q, rp_q;
      logic [LW-1:0] lvl_q;

      function automatic logic [AW-1:0] wrap_inc(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
      endfunction

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          wp_q  <= '0;
          rp_q  <= '0;
          lvl_q <= '0;
        end else begin
          if (push) wp_q <= wrap_inc(wp_q);
          if (pop)  rp_q <= wrap_inc(rp_q);
          lvl_q <= LW'(mbox_pkg::step_count(int'(lvl_q), push, pop));
        end
      end

      always_ff @(posedge clk) begin
        if (push) mem_q[wp_q] <= wdata;
      end

      assign head  = mem_q[rp_q];
      assign level = lvl_q;
    end
  endgenerate

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);

  // a push into a full queue must be paired with a pop (R10)
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  // nothing is popped from an empty queue (R5)
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/mbox_chan_count.sv
module mbox_chan_count #(
  parameter int DEPTH    = 4,
  parameter bit RST_FULL = 1'b0,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] count,
  output logic          zero
);
  localparam logic [CW-1:0] RST_VAL = RST_FULL ? CW'(DEPTH) : '0;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= CW'(mbox_pkg::step_count(int'(cnt_q), inc, dec));
  end

  assign count = cnt_q;
  assign zero  = (cnt_q == '0);

  // count stays within the queue depth (R5)
  assert_count_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH);
  // a zero count is only consumed together with a matching refill (R3, R4)
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (!zero || inc));
endmodule

// File: rtl/mbox_core_port.sv
module mbox_core_port #(
  parameter int DW  = 32,
  parameter int OCW = 1,
  parameter int ICW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     ch_op,
  input  logic [1:0]     ch_sel,
  input  logic [DW-1:0]  ch_wdata,
  input  logic [OCW-1:0] out_cnt,
  input  logic [OCW-1:0] outi_cnt,
  input  logic [ICW-1:0] in_cnt,
  input  logic           out_pop_h,
  input  logic           outi_pop_h,
  input  logic           in_wr_h,
  input  logic           in_bypass,
  input  logic [DW-1:0]  in_head,
  input  logic [DW-1:0]  hs_wdata,
  output logic           out_push_c,
  output logic           outi_push_c,
  output logic           in_pop_c,
  output logic [DW-1:0]  push_data,
  output logic [DW-1:0]  ch_rdata,
  output logic           ch_done,
  output logic           ch_stall,
  output logic           ch_err
);
  import mbox_pkg::*;

  ch_op_e  op;
  ch_sel_e sel;
  logic    active, legal;
  logic    out_room, outi_room, in_avail, ready;

  assign op     = ch_op_e'(ch_op);
  assign sel    = ch_sel_e'(ch_sel);
  assign active = (op != OP_IDLE);
  assign legal  = dir_legal(op, sel);

  // a slot or word counts as present if the host frees or supplies it now
  assign out_room  = (out_cnt  != '0) || out_pop_h;
  assign outi_room = (outi_cnt != '0) || outi_pop_h;
  assign in_avail  = (in_cnt   != '0) || in_wr_h;

  always_comb begin
    ready = 1'b1;
    case (op)
      OP_WRITE: ready = (sel == CH_OUT) ? out_room : outi_room;
      OP_READ:  ready = in_avail;
      default:  ready = 1'b1;
    endcase
  end

  assign ch_err   = active && !legal;
  assign ch_done  = active && legal && ready;
  assign ch_stall = active && legal && !ready;

  assign out_push_c  = ch_done && (op == OP_WRITE) && (sel == CH_OUT);
  assign outi_push_c = ch_done && (op == OP_WRITE) && (sel == CH_OUTI);
  assign in_pop_c    = ch_done && (op == OP_READ);
  assign push_data   = ch_wdata;

  always_comb begin
    ch_rdata = '0;
    if (ch_done) begin
      if (op == OP_READ) begin
        ch_rdata = in_bypass ? hs_wdata : in_head;
      end else if (op == OP_RCNT) begin
        case (sel)
          CH_OUT:  ch_rdata = DW'(out_cnt);
          CH_OUTI: ch_rdata = DW'(outi_cnt);
          default: ch_rdata = DW'(in_cnt);
        endcase
      end
    end
  end

  // the count query never blocks (R6)
  assert_rcnt_nonblocking_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RCNT && sel != CH_NONE) |-> ch_done);
  // a bad access neither completes nor stalls (R7)
  assert_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ch_err |-> (!ch_done && !ch_stall && !out_push_c && !outi_push_c && !in_pop_c));
endmodule

// File: rtl/mbox_host_regs.sv
module mbox_host_regs #(
  parameter int DW  = 32,
  parameter int ILW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hs_wr,
  input  logic           hs_rd,
  input  logic [1:0]     hs_addr,
  input  logic [DW-1:0]  out_head,
  input  logic [DW-1:0]  outi_head,
  input  logic           out_empty,
  input  logic           outi_empty,
  input  logic           in_full,
  input  logic [ILW-1:0] in_level,
  input  logic           in_pop_c,
  output logic           out_pop_h,
  output logic           outi_pop_h,
  output logic           in_wr_h,
  output logic           in_push_h,
  output logic [DW-1:0]  hs_rdata,
  output logic           hs_irq
);
  import mbox_pkg::*;

  logic ovf_q, drop;

  assign out_pop_h  = hs_rd && (hs_addr == HA_OUT)  && !out_empty;
  assign outi_pop_h = hs_rd && (hs_addr == HA_OUTI) && !outi_empty;
  assign in_wr_h    = hs_wr && (hs_addr == HA_IN);
  assign in_push_h  = in_wr_h && (!in_full || in_pop_c);
  assign drop       = in_wr_h && !in_push_h;

  always_ff @(posedge clk) begin
    if (!rst_n)    ovf_q <= 1'b0;
    else if (drop) ovf_q <= 1'b1;
  end

  always_comb begin
    hs_rdata = '0;
    if (hs_rd) begin
      case (hs_addr)
        HA_OUT:  hs_rdata = out_empty  ? '0 : out_head;
        HA_OUTI: hs_rdata = outi_empty ? '0 : outi_head;
        HA_STAT: begin
          hs_rdata[0]    = !out_empty;
          hs_rdata[1]    = !outi_empty;
          hs_rdata[2]    = ovf_q;
          hs_rdata[15:8] = 8'(in_level);
        end
        default: hs_rdata = '0;
      endcase
    end
  end

  assign hs_irq = !outi_empty;

  // overflow flag never clears once set (R10)
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  // an empty outgoing read returns zero (R9)
  assert_empty_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_rd && hs_addr == HA_OUT && out_empty) |-> (hs_rdata == '0 && !out_pop_h));
endmodule

// File: rtl/mbox_chan_unit.sv
module mbox_chan_unit #(
  parameter int OUT_DEPTH  = 1,
  parameter int OUTI_DEPTH = 1,
  parameter int IN_DEPTH   = 4,
  parameter int DW         = mbox_pkg::DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ch_op,
  input  logic [1:0]    ch_sel,
  input  logic [DW-1:0] ch_wdata,
  output logic [DW-1:0] ch_rdata,
  output logic          ch_done,
  output logic          ch_stall,
  output logic          ch_err,
  input  logic          hs_wr,
  input  logic          hs_rd,
  input  logic [1:0]    hs_addr,
  input  logic [DW-1:0] hs_wdata,
  output logic [DW-1:0] hs_rdata,
  output logic          hs_irq
);
  import mbox_pkg::*;

  localparam int OCW  = $clog2(OUT_DEPTH + 1);
  localparam int OICW = $clog2(OUTI_DEPTH + 1);
  localparam int ICW  = $clog2(IN_DEPTH + 1);
  localparam int CWM  = (OCW > OICW) ? OCW : OICW;

  logic [OCW-1:0]  out_cnt, out_level;
  logic [OICW-1:0] outi_cnt, outi_level;
  logic [ICW-1:0]  in_cnt, in_level;
  logic out_zero, outi_zero, in_zero;
  logic out_full, out_empty, outi_full, outi_empty, in_full, in_empty;
  logic [DW-1:0] out_head, outi_head, in_head, push_data;
  logic out_push_c, outi_push_c, in_pop_c;
  logic out_pop_h, outi_pop_h, in_wr_h, in_push_h;
  logic in_bypass, in_fifo_push, in_fifo_pop;

  // host word straight to a waiting core read when the queue is empty
  assign in_bypass    = in_empty && in_push_h && in_pop_c;
  assign in_fifo_push = in_push_h && !in_bypass;
  assign in_fifo_pop  = in_pop_c  && !in_bypass;

  mbox_core_port #(.DW(DW), .OCW(CWM), .ICW(ICW)) u_port (
    .clk, .rst_n, .ch_op, .ch_sel, .ch_wdata,
    .out_cnt(CWM'(out_cnt)), .outi_cnt(CWM'(outi_cnt)), .in_cnt(in_cnt),
    .out_pop_h, .outi_pop_h, .in_wr_h, .in_bypass, .in_head, .hs_wdata,
    .out_push_c, .outi_push_c, .in_pop_c, .push_data,
    .ch_rdata, .ch_done, .ch_stall, .ch_err
  );

  mbox_host_regs #(.DW(DW), .ILW(ICW)) u_host (
    .clk, .rst_n, .hs_wr, .hs_rd, .hs_addr,
    .out_head, .outi_head, .out_empty, .outi_empty, .in_full, .in_level,
    .in_pop_c, .out_pop_h, .outi_pop_h, .in_wr_h, .in_push_h,
    .hs_rdata, .hs_irq
  );

  mbox_fifo #(.DEPTH(OUT_DEPTH), .DW(DW)) u_out_q (
    .clk, .rst_n, .push(out_push_c), .pop(out_pop_h), .wdata(push_data),
    .head(out_head), .level(out_level), .full(out_full), .empty(out_empty)
  );
  mbox_fifo #(.DEPTH(OUTI_DEPTH), .DW(DW)) u_outi_q (
    .clk, .rst_n, .push(outi_push_c), .pop(outi_pop_h), .wdata(push_data),
    .head(outi_head), .level(outi_level), .full(outi_full), .empty(outi_empty)
  );
  mbox_fifo #(.DEPTH(IN_DEPTH), .DW(DW)) u_in_q (
    .clk, .rst_n, .push(in_fifo_push), .pop(in_fifo_pop), .wdata(hs_wdata),
    .head(in_head), .level(in_level), .full(in_full), .empty(in_empty)
  );

  mbox_chan_count #(.DEPTH(OUT_DEPTH), .RST_FULL(1'b1)) u_out_cnt (
    .clk, .rst_n, .inc(out_pop_h), .dec(out_push_c), .count(out_cnt), .zero(out_zero)
  );
  mbox_chan_count #(.DEPTH(OUTI_DEPTH), .RST_FULL(1'b1)) u_outi_cnt (
    .clk, .rst_n, .inc(outi_pop_h), .dec(outi_push_c), .count(outi_cnt), .zero(outi_zero)
  );
  mbox_chan_count #(.DEPTH(IN_DEPTH), .RST_FULL(1'b0)) u_in_cnt (
    .clk, .rst_n, .inc(in_push_h), .dec(in_pop_c), .count(in_cnt), .zero(in_zero)
  );

  // channel counts track the queue fill from separate logic (R2, R5)
  assert_out_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(out_cnt) == OUT_DEPTH - int'(out_level));
  assert_in_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_cnt == in_level);
  // outgoing stall only while full and not being drained (R3)
  assert_out_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_stall && ch_sel == CH_OUT) |-> (out_zero && out_full && !out_pop_h));
  // incoming stall only while empty and no host word arrives (R4)
  assert_in_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_stall && ch_sel == CH_IN) |-> (in_zero && in_empty && !in_wr_h));
  // interrupt follows the interrupt-queue count (R8)
  assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hs_irq == (int'(outi_cnt) != OUTI_DEPTH));
  // the interrupt queue never refuses a freed slot (R3)
  assert_outi_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_stall && ch_sel == CH_OUTI) |-> (outi_zero && outi_full));
endmodule

// File: tb/tb_mbox_chan_unit.sv
module tb_mbox_chan_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  ch_op, ch_sel, hs_addr;
  logic [31:0] ch_wdata, hs_wdata, ch_rdata, hs_rdata;
  logic        ch_done, ch_stall, ch_err, hs_wr, hs_rd, hs_irq;

  int n_vec  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  localparam logic [1:0] RD = 2'b01, WR = 2'b10, RC = 2'b11, ID = 2'b00;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mbox_chan_unit dut (
    .clk, .rst_n, .ch_op, .ch_sel, .ch_wdata, .ch_rdata, .ch_done, .ch_stall,
    .ch_err, .hs_wr, .hs_rd, .hs_addr, .hs_wdata, .hs_rdata, .hs_irq
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // apply inputs after a falling edge and let combinational outputs settle
  task automatic step(logic [1:0] op, logic [1:0] sel, logic [31:0] cw,
                      logic w, logic r, logic [1:0] a, logic [31:0] hw);
    @(negedge clk);
    ch_op = op; ch_sel = sel; ch_wdata = cw;
    hs_wr = w; hs_rd = r; hs_addr = a; hs_wdata = hw;
    #1;
  endtask

  task automatic idle();
    step(ID, 2'd0, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0);
  endtask

  task automatic expect_count(string req, logic [1:0] sel, int exp);
    step(RC, sel, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0);
    chk(req, ch_rdata, 32'(exp));
    chk(req, {ch_done, ch_stall}, 32'b10);
  endtask

  task automatic host_read(string req, logic [1:0] a, logic [31:0] exp);
    step(ID, 2'd0, 32'h0, 1'b0, 1'b1, a, 32'h0);
    chk(req, hs_rdata, exp);
  endtask

  task automatic host_write(logic [31:0] d);
    step(ID, 2'd0, 32'h0, 1'b1, 1'b0, 2'd2, d);
  endtask

  task automatic t_reset();
    expect_count("R1", 2'd0, 1);
    expect_count("R1", 2'd1, 1);
    expect_count("R1", 2'd2, 0);
    chk("R1", {hs_irq, ch_err}, 32'b0);
    host_read("R1", 2'd3, 32'h0);
  endtask

  task automatic t_write_out();
    step(WR, 2'd0, 32'hA0A0_0001, 1'b0, 1'b0, 2'd0, 32'h0);
    chk("R2", {ch_done, ch_stall, ch_err}, 32'b100);
    expect_count("R2", 2'd0, 0);
    chk("R8", hs_irq, 32'b0);
    host_read("R11", 2'd3, 32'h0000_0001);
    host_read("R2", 2'd0, 32'hA0A0_0001);
    expect_count("R2", 2'd0, 1);
  endtask

  task automatic t_out_stall();
    step(WR, 2'd0, 32'hB0B0_0002, 1'b0, 1'b0, 2'd0, 32'h0);
    for (int i = 0; i < 3; i++) begin
      step(WR, 2'd0, 32'hC0C0_0003, 1'b0, 1'b0, 2'd0, 32'h0);
      chk("R3", {ch_done, ch_stall}, 32'b01);
    end
    step(WR, 2'd0, 32'hC0C0_0003, 1'b0, 1'b1, 2'd0, 32'h0);
    chk("R3", {ch_done, ch_stall}, 32'b10);
    chk("R3", hs_rdata, 32'hB0B0_0002);
    expect_count("R3", 2'd0, 0);
    host_read("R3", 2'd0, 32'hC0C0_0003);
    expect_count("R3", 2'd0, 1);
  endtask

  task automatic t_in_stall();
    for (int i = 0; i < 2; i++) begin
      step(RD, 2'd2, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0);
      chk("R4", {ch_done, ch_stall}, 32'b01);
    end
    step(RD, 2'd2, 32'h0, 1'b1, 1'b0, 2'd2, 32'hD0D0_0004);
    chk("R4", {ch_done, ch_stall}, 32'b10);
    chk("R4", ch_rdata, 32'hD0D0_0004);
    expect_count("R4", 2'd2, 0);
    expect_count("R6", 2'd2, 0);
  endtask

  task automatic t_in_fifo();
    for (int i = 0; i < 4; i++) host_write(32'h1000 + 32'(i));
    expect_count("R5", 2'd2, 4);
    host_read("R11", 2'd3, 32'h0000_0400);
    host_write(32'hDEAD_BEEF);
    host_read("R10", 2'd3, 32'h0000_0404);
    expect_count("R10", 2'd2, 4);
    host_read("R11", 2'd2, 32'h0);
    for (int i = 0; i < 4; i++) begin
      step(RD, 2'd2, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0);
      chk("R5", ch_rdata, 32'h1000 + 32'(i));
    end
    expect_count("R5", 2'd2, 0);
    host_read("R10", 2'd3, 32'h0000_0004);
  endtask

  task automatic t_errors();
    host_write(32'h5555_0005);
    step(RD, 2'd0, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0);
    chk("R7", {ch_err, ch_done, ch_stall}, 32'b100);
    step(RD, 2'd1, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0);
    chk("R7", {ch_err, ch_done, ch_stall}, 32'b100);
    step(WR, 2'd2, 32'h77, 1'b0, 1'b0, 2'd0, 32'h0);
    chk("R7", {ch_err, ch_done, ch_stall}, 32'b100);
    step(WR, 2'd3, 32'h77, 1'b0, 1'b0, 2'd0, 32'h0);
    chk("R7", {ch_err, ch_done, ch_stall}, 32'b100);
    idle();
    chk("R7", ch_err, 32'b0);
    expect_count("R7", 2'd0, 1);
    expect_count("R7", 2'd1, 1);
    expect_count("R7", 2'd2, 1);
    step(RD, 2'd2, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0);
    chk("R7", ch_rdata, 32'h5555_0005);
  endtask

  task automatic t_irq_and_empty();
    host_read("R9", 2'd0, 32'h0);
    host_read("R9", 2'd1, 32'h0);
    expect_count("R9", 2'd0, 1);
    step(WR, 2'd1, 32'hE0E0_0006, 1'b0, 1'b0, 2'd0, 32'h0);
    chk("R2", ch_done, 32'b1);
    idle();
    chk("R8", hs_irq, 32'b1);
    expect_count("R2", 2'd1, 0);
    host_read("R8", 2'd1, 32'hE0E0_0006);
    idle();
    chk("R8", hs_irq, 32'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    ch_op = ID; ch_sel = 2'd0; ch_wdata = '0;
    hs_wr = 1'b0; hs_rd = 1'b0; hs_addr = 2'd0; hs_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_out();
    t_out_stall();
    t_in_stall();
    t_in_fifo();
    t_errors();
    t_irq_and_empty();
    idle();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule